// File: doc/BRIEF.md
# Multiplexed-Bus Discrete I/O Expander

This block is a slave on an 8-bit multiplexed address/data bus. It serves one 32-bit field input port and one 32-bit field output port. Both ports are meant for opto-isolated discrete signals. A 5-bit board-select input decides which 8-byte window of the 256-byte bus space the block answers to. The host first presents an address with a latch strobe. It then moves a full 32-bit word as four byte strobes, least significant byte first. No single-bit access exists. The two low address bits act as per-access inhibits, so a port can be named read-only or write-only. They are not byte selects.

Field pins are active-low. A word bit of 1 drives its output pin low, and a low input pin reads as 1. An incoming write is gathered in a shadow register. It reaches the output latch in a single step after the fourth byte, so a half-written word never appears on the pins. A local watchdog counts clock cycles between accesses to this board. If the host falls silent for longer than the timeout, the watchdog forces every output pin high, which turns all field outputs off. The trip stays in force until the next access to this board.

Top module: `dio_xpdr`

## Requirements
- R1: An address phase hits this board only when address bits [7:3] equal `board_sel`. Byte strobes after a non-hitting address phase leave the outputs unchanged, and their reads return 0x00.
- R2: Address bit 2 picks the port: 0 is the input port (window base) and 1 is the output port (base+4). Writes to the input port have no effect on the outputs.
- R3: When address bit 0 of the current address phase is 1, byte writes are discarded and the output latch keeps its value.
- R4: When address bit 1 of the current address phase is 1, every byte read returns 0x00.
- R5: A word moves as four byte strobes, least significant byte first. Each address phase resets the byte-lane counter to lane 0. A read byte appears on `bus_rd_data` in the cycle after its `bus_rd` strobe.
- R6: The output latch changes only on the fourth write byte of a word. After one to three bytes, or after a new address phase, the pins still show the previous word.
- R7: The pins follow negative logic: `field_out_n` equals the bitwise inverse of the latched word, and an input read returns the inverse of `field_in_n`. The input is sampled at the address phase.
- R8: Reset clears the output latch, so all pins are high. It also clears the read data and restarts the watchdog, and a readback of the output port then returns zero.
- R9: While `wdog_en` is 1, TIMEOUT cycles without a byte access to this board trip the watchdog. A tripped watchdog drives every output pin high.
- R10: A trip holds until the next read or write byte strobe to this board. That strobe clears the trip and restarts the period. The pins then show the latched word again.
- R11: While `wdog_en` is 0, the watchdog never trips.
- R12: A permitted read of the output port returns the latched output word, with bit 1 meaning asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| board_sel | input | 5 | Window select; window base = board_sel × 8 |
| bus_ale | input | 1 | Address phase strobe; `bus_ad` carries the address |
| bus_rd | input | 1 | Read byte strobe |
| bus_wr | input | 1 | Write byte strobe; `bus_ad` carries the data |
| bus_ad | input | 8 | Multiplexed address/write-data byte |
| bus_rd_data | output | 8 | Read data byte, registered |
| wdog_en | input | 1 | Watchdog enable (tie high for default operation) |
| field_in_n | input | 32 | Active-low field inputs |
| field_out_n | output | 32 | Active-low field outputs |

## Verification
The assertions check the following on every cycle:
- a tripped watchdog always means all-high pins;
- the pins never move without a write strobe unless the trip state changed;
- read-inhibited and foreign reads yield zero;
- an access to this board always clears the trip;
- a disabled watchdog never trips.

Other behaviours need whole sequences, so only the bench scenarios can show them:
- the byte order within a word;
- the lane counter resetting on a new address phase;
- the input being captured at the address phase;
- the trip coming only after the full timeout;
- the latched word coming back after a trip.

// File: rtl/dio_xpdr_pkg.sv
package dio_xpdr_pkg;

    // Which port an address phase selected (address bit 2 of the window)
    typedef enum logic {
        PORT_IN  = 1'b0,
        PORT_OUT = 1'b1
    } port_e;

endpackage

// File: rtl/dio_addr_decode.sv
module dio_addr_decode
    import dio_xpdr_pkg::*;
#(
    parameter int BUS_W  = 8,
    parameter int SEL_W  = 5,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic              rd,
    input  logic              wr,
    input  logic [BUS_W-1:0]  ad,
    input  logic [SEL_W-1:0]  sel,
    output logic              hit,
    output port_e             port,
    output logic              rd_blk,
    output logic              wr_blk,
    output logic [LANE_W-1:0] lane
);

    localparam int WIN_LSB = BUS_W - SEL_W;

    typedef struct packed {
        logic              hit;
        port_e             port;
        logic              rd_blk;
        logic              wr_blk;
        logic [LANE_W-1:0] lane;
    } dec_t;

    dec_t dec_d, dec_q;

    always_comb begin
        dec_d = dec_q;
        if (ale) begin
            dec_d.hit    = (ad[BUS_W-1 -: SEL_W] == sel);
            dec_d.port   = port_e'(ad[WIN_LSB-1]);
            dec_d.rd_blk = ad[1];
            dec_d.wr_blk = ad[0];
            dec_d.lane   = '0;
        end else if (dec_q.hit && (rd || wr)) begin
            dec_d.lane = dec_q.lane + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q <= '{hit: 1'b0, port: PORT_IN, rd_blk: 1'b1, wr_blk: 1'b1, lane: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

    assign hit    = dec_q.hit;
    assign port   = dec_q.port;
    assign rd_blk = dec_q.rd_blk;
    assign wr_blk = dec_q.wr_blk;
    assign lane   = dec_q.lane;

endmodule

// File: rtl/dio_out_stage.sv
module dio_out_stage #(
    parameter int WORD_W = 32,
    parameter int BUS_W  = 8,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] lane,
    input  logic [BUS_W-1:0]  data,
    output logic [WORD_W-1:0] latch
);

    localparam int                LANES     = WORD_W / BUS_W;
    localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shadow;
        logic [WORD_W-1:0] latch;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (wr_en) begin
            out_d.shadow[lane*BUS_W +: BUS_W] = data;
            if (lane == LAST_LANE) begin
                out_d.latch = out_d.shadow;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign latch = out_q.latch;

endmodule

// File: rtl/dio_wdog.sv
module dio_wdog #(
    parameter int TIMEOUT = 37_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic kick,
    output logic trip
);

    localparam int               CNT_W = $clog2(TIMEOUT + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trip;
    } wd_t;

    wd_t wd_d, wd_q;

    always_comb begin
        wd_d = wd_q;
        if (!en || kick) begin
            wd_d.cnt  = '0;
            wd_d.trip = 1'b0;
        end else if (!wd_q.trip) begin
            if (wd_q.cnt == LAST) begin
                wd_d.cnt  = '0;
                wd_d.trip = 1'b1;
            end else begin
                wd_d.cnt = wd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_q <= '0;
        end else begin
            wd_q <= wd_d;
        end
    end

    assign trip = wd_q.trip;

endmodule

// File: rtl/dio_xpdr.sv
module dio_xpdr
    import dio_xpdr_pkg::*;
#(
    parameter int BUS_W   = 8,
    parameter int SEL_W   = 5,
    parameter int WORD_W  = 32,
    parameter int TIMEOUT = 37_500_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  board_sel,
    input  logic              bus_ale,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_ad,
    output logic [BUS_W-1:0]  bus_rd_data,
    input  logic              wdog_en,
    input  logic [WORD_W-1:0] field_in_n,
    output logic [WORD_W-1:0] field_out_n
);

    localparam int LANES  = WORD_W / BUS_W;
    localparam int LANE_W = $clog2(LANES);

    logic              hit;
    port_e             port;
    logic              rd_blk;
    logic              wr_blk;
    logic [LANE_W-1:0] lane;
    logic [WORD_W-1:0] latch;
    logic              trip;
    logic              wr_en;
    logic              kick;

    dio_addr_decode #(
        .BUS_W (BUS_W),
        .SEL_W (SEL_W),
        .LANE_W(LANE_W)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .ale   (bus_ale),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .ad    (bus_ad),
        .sel   (board_sel),
        .hit   (hit),
        .port  (port),
        .rd_blk(rd_blk),
        .wr_blk(wr_blk),
        .lane  (lane)
    );

    assign wr_en = bus_wr && hit && !wr_blk && (port == PORT_OUT);
    assign kick  = hit && (bus_rd || bus_wr);

    dio_out_stage #(
        .WORD_W(WORD_W),
        .BUS_W (BUS_W),
        .LANE_W(LANE_W)
    ) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .lane (lane),
        .data (bus_ad),
        .latch(latch)
    );

    dio_wdog #(
        .TIMEOUT(TIMEOUT)
    ) u_wd (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (wdog_en),
        .kick (kick),
        .trip (trip)
    );

    // Input snapshot at the address phase and registered read data
    typedef struct packed {
        logic [WORD_W-1:0] snap;
        logic [BUS_W-1:0]  rdat;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (bus_ale) begin
            rd_d.snap = ~field_in_n;
        end
        if (bus_rd) begin
            if (hit && !rd_blk) begin
                rd_d.rdat = (port == PORT_IN) ? rd_q.snap[lane*BUS_W +: BUS_W]
                                              : latch[lane*BUS_W +: BUS_W];
            end else begin
                rd_d.rdat = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign bus_rd_data = rd_q.rdat;
    assign field_out_n = ~latch | {WORD_W{trip}};

endmodule

// File: rtl/dio_xpdr_chk.sv
module dio_xpdr_chk #(
    parameter int BUS_W  = 8,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic              wdog_en,
    input logic              hit,
    input logic              rd_blk,
    input logic              trip,
    input logic [BUS_W-1:0]  bus_rd_data,
    input logic [WORD_W-1:0] field_out_n
);

    // R9: a tripped watchdog leaves every pin high
    a_r9_trip_pins_off: assert property (@(posedge clk) disable iff (!rst_n)
        trip |-> (field_out_n == '1));

    // R6: pins move only after a write strobe or a trip change
    a_r6_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(field_out_n) || !$stable(trip)));

    // R4: a read-inhibited read yields zero
    a_r4_read_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit && rd_blk) |=> (bus_rd_data == '0));

    // R1: a read with no window hit yields zero
    a_r1_foreign_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !hit) |=> (bus_rd_data == '0));

    // R10: an access to this board clears the trip
    a_r10_access_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && hit) |=> !trip);

    // R11: a disabled watchdog cannot trip
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wdog_en |=> !trip);

endmodule

bind dio_xpdr dio_xpdr_chk #(
    .BUS_W (BUS_W),
    .WORD_W(WORD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .wdog_en    (wdog_en),
    .hit        (hit),
    .rd_blk     (rd_blk),
    .trip       (trip),
    .bus_rd_data(bus_rd_data),
    .field_out_n(field_out_n)
);

// File: tb/dio_xpdr_tb.sv
module dio_xpdr_tb;

    localparam int TIMEOUT = 300;
    localparam logic [4:0] SEL = 5'd9;            // window base 72
    localparam logic [7:0] IN_RO  = 8'd73;        // input port, write inhibited
    localparam logic [7:0] IN_RW  = 8'd72;        // input port, no inhibit
    localparam logic [7:0] OUT_WO = 8'd78;        // output port, read inhibited
    localparam logic [7:0] OUT_RW = 8'd76;        // output port, no inhibit
    localparam logic [7:0] OUT_RO = 8'd77;        // output port, write inhibited
    localparam logic [7:0] OTHER  = 8'd86;        // board 10 output port

    // {output word, input word}
    localparam logic [63:0] VEC [4] = '{
        {32'hA5C3_0F81, 32'h1234_5678},
        {32'hFFFF_FFFF, 32'h0000_0000},
        {32'h0000_0001, 32'hFFFF_FFFF},
        {32'h8000_0000, 32'hDEAD_BEEF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_ale = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_ad = '0;
    logic [7:0]  bus_rd_data;
    logic        wdog_en = 1'b1;
    logic [31:0] field_in_n = '1;
    logic [31:0] field_out_n;

    int n_run = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    dio_xpdr #(.TIMEOUT(TIMEOUT)) u_dut (
        .clk(clk), .rst_n(rst_n), .board_sel(SEL),
        .bus_ale(bus_ale), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_ad(bus_ad),
        .bus_rd_data(bus_rd_data), .wdog_en(wdog_en),
        .field_in_n(field_in_n), .field_out_n(field_out_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic addr_ph(input logic [7:0] a);
        @(negedge clk); bus_ale = 1'b1; bus_ad = a;
        @(negedge clk); bus_ale = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_ad = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [7:0] a, input logic [31:0] w);
        addr_ph(a);
        for (int i = 0; i < 4; i++) wr_byte(w[i*8 +: 8]);
    endtask

    task automatic rd_word(input logic [7:0] a, output logic [31:0] w);
        addr_ph(a);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bus_rd = 1'b1;
            @(negedge clk); bus_rd = 1'b0;
            w[i*8 +: 8] = bus_rd_data;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] cur;
        idle(4);
        rst_n = 1'b1;
        idle(1);
        // R8: reset state
        check("R8 pins after reset", field_out_n, 32'hFFFF_FFFF);
        check("R8 read data after reset", {24'h0, bus_rd_data}, 32'h0);

        // Vector table: R5 R6 R7 R12
        for (int k = 0; k < 4; k++) begin
            field_in_n = ~VEC[k][31:0];
            wr_word(OUT_WO, VEC[k][63:32]);
            idle(1);
            check("R7 output pins", field_out_n, ~VEC[k][63:32]);
            rd_word(IN_RO, r);
            check("R5 input word LSB first", r, VEC[k][31:0]);
            rd_word(OUT_RW, r);
            check("R12 output readback", r, VEC[k][63:32]);
        end
        cur = VEC[3][63:32];

        // R3: write-inhibited address
        wr_word(OUT_RO, 32'h1357_9BDF);
        idle(1);
        check("R3 write inhibit", field_out_n, ~cur);

        // R4: read-inhibited address returns zero
        rd_word(OUT_WO, r);
        check("R4 read inhibit", r, 32'h0);

        // R2: write to input port ignored
        wr_word(IN_RW, 32'h2468_ACE0);
        idle(1);
        check("R2 input port write ignored", field_out_n, ~cur);

        // R1: other board's window
        wr_word(OTHER, 32'h0F0F_0F0F);
        idle(1);
        check("R1 foreign write ignored", field_out_n, ~cur);
        rd_word(OTHER - 8'd5, r);
        check("R1 foreign read zero", r, 32'h0);

        // R6/R5: partial word, then new address resets the lane
        addr_ph(OUT_WO);
        wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33);
        idle(1);
        check("R6 partial word held back", field_out_n, ~cur);
        wr_word(OUT_WO, 32'h4433_2211);
        idle(1);
        check("R5 lane reset after new address", field_out_n, ~32'h4433_2211);
        cur = 32'h4433_2211;

        // R7: input captured at the address phase
        field_in_n = ~32'hCAFE_0001;
        addr_ph(IN_RO);
        field_in_n = ~32'h0BAD_0002;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); bus_rd = 1'b1;
            @(negedge clk); bus_rd = 1'b0;
            r[i*8 +: 8] = bus_rd_data;
        end
        check("R7 input snapshot", r, 32'hCAFE_0001);

        // R9: watchdog trip after TIMEOUT idle cycles
        idle(TIMEOUT / 3);
        check("R9 no trip before timeout", field_out_n, ~cur);
        idle(TIMEOUT);
        check("R9 trip forces pins high", field_out_n, 32'hFFFF_FFFF);

        // R10: access clears the trip, latch preserved
        rd_word(IN_RO, r);
        idle(1);
        check("R10 access restores pins", field_out_n, ~cur);

        // R11: disabled watchdog never trips
        wdog_en = 1'b0;
        idle(3 * TIMEOUT);
        check("R11 disabled watchdog", field_out_n, ~cur);
        wdog_en = 1'b1;

        // R8: reset mid-run clears the latch
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        check("R8 pins after mid-run reset", field_out_n, 32'hFFFF_FFFF);
        rd_word(OUT_RW, r);
        check("R8 latch cleared by reset", r, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule